// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital sequencer that sits in front of a multiplexed successive-approximation converter core. Software writes one control word holding a grouping-mode bit, a continuous-scan bit and a 4-bit channel code. That write starts a sequence of four conversions. For each conversion the block drives the analog multiplexer select, pulses a start strobe to the converter core and waits for the core's done pulse. It then files the returned sample into one of four result registers. After the fourth result it raises a sequence-complete flag.

In single-channel mode the same channel is sampled four times and the four samples fill the registers in order. In grouped mode the upper two code bits pick a bank of four consecutive channel codes, and each channel of the bank is sampled once into its own register. Some channel codes select internal reference sources and some are reserved. Every code runs through the same sequence; what it returns is up to the core. With scan enabled the sequence repeats without end and overwrites the registers in the same order. Any new control write abandons the work in progress and starts again from the first register.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With cfg_multi=0, a write starts four conversions that all drive mux_sel equal to cfg_code. The results land in slots 1, 2, 3 and 4 of res_bus in that order. Slot k occupies bits [k*RES_W-1:(k-1)*RES_W].
- R2: With cfg_multi=1, conversion k (k=0..3) drives mux_sel={cfg_code[3:2], k} and its result lands in slot k+1. cfg_code[1:0] has no effect.
- R3: conv_start is a single-cycle pulse. The next pulse comes only after a done has been accepted. A done that arrives while no conversion is awaited is ignored.
- R4: res_bus changes only in the cycle after an accepted conv_done. Exactly one slot changes at that point, and it takes conv_data.
- R5: With cfg_scan=0, seq_done rises in the cycle after the fourth accepted result, busy falls, and no further conv_start occurs until the next write.
- R6: With cfg_scan=1, the fourth result sets seq_done and the sequence continues at once at conversion 0. It keeps looping, overwriting slots 1 to 4, with busy held high and seq_done held set.
- R7: A cfg_wr in any cycle clears seq_done and restarts at conversion 0, with conv_start in the next cycle. A conv_done that falls in the same cycle as cfg_wr is discarded and no slot changes.
- R8: Reserved codes (10xx, 1111) and reference codes (1100, 1101, 1110) run a full sequence like any channel code. When the core returns zero for a reserved code, the slot holds zero.
- R9: After reset, seq_done, busy, conv_start, mux_sel and every result slot are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control write strobe; starts or restarts a sequence |
| cfg_multi | input | 1 | 1 = grouped channels, 0 = one channel four times |
| cfg_scan | input | 1 | 1 = loop continuously |
| cfg_code | input | 4 | Channel select code |
| mux_sel | output | 4 | Analog multiplexer select for the current conversion |
| conv_start | output | 1 | One-cycle start strobe to the converter core |
| conv_done | input | 1 | One-cycle done pulse from the converter core |
| conv_data | input | RES_W | Conversion result, valid with conv_done |
| res_bus | output | NUM_SLOTS*RES_W | Result slots, slot 1 in the low bits |
| seq_done | output | 1 | Sequence-complete flag |
| busy | output | 1 | A sequence is in progress |

## Verification
A control write and the core's done pulse can fall in the same clock edge. In that case the write must win: the pending sample is dropped, the flag is cleared and the sequence restarts. The bench provokes this by waiting until it sees the done pulse high between edges and driving the write in that same cycle. It then judges the outcome three ways: every result slot must be unchanged, the flag must be clear, and a new start must appear with the new code on the multiplexer select. A cycle-by-cycle behavioural model also gives its own verdict on every cycle around the collision.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int CODE_W = 4;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_START = 2'd1,
      PH_WAIT  = 2'd2
   } phase_t;

   typedef struct packed {
      logic              multi;
      logic              scan;
      logic [CODE_W-1:0] code;
   } seq_cfg_t;
endpackage

// File: rtl/adc_chan_map.sv
module adc_chan_map
   import adc_seq_pkg::*;
#(
   parameter int IDX_W = 2
) (
   input  seq_cfg_t          cfg,
   input  logic [IDX_W-1:0]  idx,
   output logic [CODE_W-1:0] chan
);
   logic [CODE_W-1:0] grouped;

   generate
      if (IDX_W == CODE_W) begin : g_full
         assign grouped = idx;
      end else begin : g_bank
         assign grouped = {cfg.code[CODE_W-1:IDX_W], idx};
      end
   endgenerate

   assign chan = cfg.multi ? grouped : cfg.code;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   localparam int IDX_W = $clog2(NUM_SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  seq_cfg_t         cfg_in,
   input  logic             conv_done,
   output seq_cfg_t         cfg_q,
   output logic [IDX_W-1:0] idx,
   output logic             accept,
   output logic             conv_start,
   output logic             busy,
   output logic             seq_done
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

   phase_t phase;
   logic   last;

   assign accept     = (phase == PH_WAIT) && conv_done && !cfg_wr;
   assign last       = (idx == LAST_IDX);
   assign conv_start = (phase == PH_START);
   assign busy       = (phase != PH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         idx      <= '0;
         cfg_q    <= '0;
         seq_done <= 1'b0;
      end else if (cfg_wr) begin
         cfg_q    <= cfg_in;
         idx      <= '0;
         phase    <= PH_START;
         seq_done <= 1'b0;
      end else begin
         case (phase)
            PH_START: phase <= PH_WAIT;
            PH_WAIT: begin
               if (accept) begin
                  if (last) begin
                     seq_done <= 1'b1;
                     idx      <= '0;
                     phase    <= cfg_q.scan ? PH_START : PH_IDLE;
                  end else begin
                     idx   <= idx + 1'b1;
                     phase <= PH_START;
                  end
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int RES_W     = 10,
   parameter int NUM_SLOTS = 4,
   localparam int IDX_W = $clog2(NUM_SLOTS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_slot,
   input  logic [RES_W-1:0]           wr_data,
   output logic [NUM_SLOTS*RES_W-1:0] res_bus
);
   genvar s;
   generate
      for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
         logic [RES_W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot_q <= '0;
            end else if (wr_en && (wr_slot == IDX_W'(s))) begin
               slot_q <= wr_data;
            end
         end
         assign res_bus[s*RES_W +: RES_W] = slot_q;
      end
   endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int RES_W     = 10,
   parameter int NUM_SLOTS = 4,
   localparam int IDX_W = $clog2(NUM_SLOTS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_wr,
   input  logic                       cfg_multi,
   input  logic                       cfg_scan,
   input  logic [3:0]                 cfg_code,
   output logic [3:0]                 mux_sel,
   output logic                       conv_start,
   input  logic                       conv_done,
   input  logic [RES_W-1:0]           conv_data,
   output logic [NUM_SLOTS*RES_W-1:0] res_bus,
   output logic                       seq_done,
   output logic                       busy
);
   generate
      if (NUM_SLOTS < 2 || (NUM_SLOTS & (NUM_SLOTS - 1)) != 0) begin : g_bad_slots
         $error("NUM_SLOTS must be a power of two, at least 2");
      end
      if (IDX_W > CODE_W) begin : g_bad_idx
         $error("NUM_SLOTS exceeds the channel code range");
      end
      if (RES_W < 1) begin : g_bad_res
         $error("RES_W must be positive");
      end
   endgenerate

   seq_cfg_t         cfg_in, cfg_q;
   logic [IDX_W-1:0] idx;
   logic             accept;

   assign cfg_in = '{multi: cfg_multi, scan: cfg_scan, code: cfg_code};

   adc_seq_fsm #(.NUM_SLOTS(NUM_SLOTS)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_in     (cfg_in),
      .conv_done  (conv_done),
      .cfg_q      (cfg_q),
      .idx        (idx),
      .accept     (accept),
      .conv_start (conv_start),
      .busy       (busy),
      .seq_done   (seq_done)
   );

   adc_chan_map #(.IDX_W(IDX_W)) u_map (
      .cfg  (cfg_q),
      .idx  (idx),
      .chan (mux_sel)
   );

   adc_result_bank #(.RES_W(RES_W), .NUM_SLOTS(NUM_SLOTS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (accept),
      .wr_slot (idx),
      .wr_data (conv_data),
      .res_bus (res_bus)
   );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int RES_W     = 10,
   parameter int NUM_SLOTS = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cfg_wr,
   input logic                       conv_start,
   input logic                       conv_done,
   input logic                       busy,
   input logic                       seq_done,
   input logic [NUM_SLOTS*RES_W-1:0] res_bus
);
   // R3
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cfg_wr) |=> !conv_start);

   // R7
   wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (!seq_done && conv_start));

   // R4
   res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!conv_done || cfg_wr) |=> $stable(res_bus));

   // R5
   flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_done) |-> $past(conv_done));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W), .NUM_SLOTS(NUM_SLOTS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .conv_start (conv_start),
   .conv_done  (conv_done),
   .busy       (busy),
   .seq_done   (seq_done),
   .res_bus    (res_bus)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/100ps
module sim_adc_seq_ctrl;
   localparam int RW  = 10;
   localparam int LAT = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0, cfg_multi = 1'b0, cfg_scan = 1'b0;
   logic [3:0] cfg_code = 4'd0;
   logic [3:0] mux_sel;
   logic conv_start, conv_done, seq_done, busy;
   logic [RW-1:0] conv_data;
   logic [4*RW-1:0] res_bus;

   logic stub_done = 1'b0, inj_done = 1'b0;
   logic [RW-1:0] stub_data = '0;
   logic [3:0] stub_code = 4'd0;
   logic [5:0] stub_cnt = 6'd0;
   int stub_left = 0;
   int nstart = 0;

   int tests = 0, fails = 0;
   bit finished = 1'b0;

   assign conv_done = stub_done | inj_done;
   assign conv_data = inj_done ? {RW{1'b1}} : stub_data;

   always #2.5 clk = ~clk;

   adc_seq_ctrl #(.RES_W(RW), .NUM_SLOTS(4)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_multi(cfg_multi),
      .cfg_scan(cfg_scan), .cfg_code(cfg_code), .mux_sel(mux_sel),
      .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
      .res_bus(res_bus), .seq_done(seq_done), .busy(busy)
   );

   // converter stub: restarts on every start, zero for reserved codes
   always @(posedge clk) begin
      stub_done <= 1'b0;
      if (conv_start) begin
         stub_left = LAT;
         stub_code <= mux_sel;
         stub_cnt  <= stub_cnt + 6'd1;
         nstart    = nstart + 1;
      end else if (stub_left > 0) begin
         stub_left = stub_left - 1;
         if (stub_left == 0) begin
            stub_done <= 1'b1;
            stub_data <= (stub_code[3:2] == 2'b10 || stub_code == 4'hF) ? '0 : {stub_code, stub_cnt};
         end
      end
   end

   // behavioural reference model
   int m_ph = 0, m_idx = 0;
   bit m_multi = 0, m_scan = 0, m_flag = 0;
   logic [3:0] m_code = 0;
   logic [RW-1:0] m_res [4];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_idx = 0; m_flag = 0; m_multi = 0; m_scan = 0; m_code = 0;
         for (int i = 0; i < 4; i++) m_res[i] = '0;
      end else if (cfg_wr) begin
         m_multi = cfg_multi; m_scan = cfg_scan; m_code = cfg_code;
         m_idx = 0; m_ph = 1; m_flag = 0;
      end else if (m_ph == 1) begin
         m_ph = 2;
      end else if (m_ph == 2 && conv_done) begin
         m_res[m_idx] = conv_data;
         if (m_idx == 3) begin
            m_flag = 1; m_idx = 0; m_ph = m_scan ? 1 : 0;
         end else begin
            m_idx = m_idx + 1; m_ph = 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [RW-1:0] slot(input int k);
      return res_bus[k*RW +: RW];
   endfunction

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [3:0] em;
         em = m_multi ? {m_code[3:2], 2'(m_idx)} : m_code;
         chk(conv_start == (m_ph == 1), "R3 model conv_start", int'(conv_start), int'(m_ph == 1));
         chk(mux_sel == em, m_multi ? "R2 model mux_sel" : "R1 model mux_sel", int'(mux_sel), int'(em));
         chk(seq_done == m_flag, "R5 model seq_done", int'(seq_done), int'(m_flag));
         chk(busy == (m_ph != 0), "R6 model busy", int'(busy), int'(m_ph != 0));
         for (int k = 0; k < 4; k++)
            chk(slot(k) == m_res[k], "R4 model result slot", int'(slot(k)), int'(m_res[k]));
      end
   end

   task automatic write_cfg(input bit mu, input bit sc, input logic [3:0] cd);
      cfg_multi = mu; cfg_scan = sc; cfg_code = cd; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 400 && busy; i++) @(negedge clk);
   endtask

   initial begin : watchdog
      #(5ns * 20000);
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : stim
      logic [4*RW-1:0] snap;
      logic [5:0] c0;
      repeat (3) @(negedge clk);
      chk(seq_done == 0 && busy == 0 && conv_start == 0 && mux_sel == 0 && res_bus == '0,
          "R9 reset state", int'(res_bus != '0), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // single channel
      write_cfg(1'b0, 1'b0, 4'b0101);
      chk(conv_start == 1 && mux_sel == 4'b0101, "R7 start after write", int'(mux_sel), 5);
      wait_idle();
      chk(seq_done == 1, "R5 flag after fourth", int'(seq_done), 1);
      for (int k = 0; k < 4; k++)
         chk(slot(k)[9:6] == 4'b0101, "R1 slot code", int'(slot(k)[9:6]), 5);
      for (int k = 1; k < 4; k++)
         chk(slot(k)[5:0] == slot(k-1)[5:0] + 6'd1, "R1 slot order", int'(slot(k)[5:0]), int'(slot(k-1)[5:0] + 6'd1));
      c0 = nstart[5:0];
      repeat (10) @(negedge clk);
      chk(nstart[5:0] == c0 && busy == 0, "R5 stopped", nstart, int'(c0));

      // stray done while idle
      snap = res_bus;
      inj_done = 1'b1; @(negedge clk); inj_done = 1'b0; @(negedge clk);
      chk(res_bus == snap, "R3 stray done ignored", int'(slot(0)), int'(snap[RW-1:0]));

      // grouped, low bits must not matter
      write_cfg(1'b1, 1'b0, 4'b0110);
      wait_idle();
      for (int k = 0; k < 4; k++)
         chk(slot(k)[9:6] == {2'b01, 2'(k)}, "R2 grouped slot", int'(slot(k)[9:6]), 4 + k);

      // reserved and reference codes
      write_cfg(1'b0, 1'b0, 4'b1010);
      wait_idle();
      chk(seq_done == 1 && res_bus == '0, "R8 reserved single", int'(res_bus != '0), 0);
      write_cfg(1'b0, 1'b0, 4'b1100);
      wait_idle();
      chk(seq_done == 1 && slot(3)[9:6] == 4'b1100, "R8 reference code", int'(slot(3)[9:6]), 12);

      // grouped scan over the reference bank
      write_cfg(1'b1, 1'b1, 4'b1101);
      c0 = nstart[5:0];
      for (int i = 0; i < 400 && (nstart - int'(c0)) < 6; i++) @(negedge clk);
      snap = res_bus;
      for (int i = 0; i < 400 && (nstart - int'(c0)) < 13; i++) @(negedge clk);
      chk(busy == 1 && seq_done == 1, "R6 scan loops", int'(busy), 1);
      chk(slot(3) == '0, "R8 reserved in bank", int'(slot(3)), 0);
      chk(slot(0)[9:6] == 4'b1100 && slot(0)[5:0] != snap[5:0], "R6 overwrite", int'(slot(0)), int'(snap[RW-1:0]));

      // abort mid-scan
      write_cfg(1'b0, 1'b0, 4'b0011);
      chk(seq_done == 0 && conv_start == 1 && mux_sel == 4'b0011, "R7 abort", int'(seq_done), 0);
      wait_idle();
      chk(slot(0)[9:6] == 4'b0011 && slot(3)[9:6] == 4'b0011, "R7 restart from slot 1", int'(slot(0)[9:6]), 3);

      // collision of write and done
      write_cfg(1'b1, 1'b0, 4'b0000);
      for (int i = 0; i < 100 && !conv_done; i++) @(negedge clk);
      snap = res_bus;
      cfg_multi = 1'b0; cfg_scan = 1'b0; cfg_code = 4'b0111; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      chk(res_bus == snap, "R7 collision done discarded", int'(slot(0)), int'(snap[RW-1:0]));
      chk(seq_done == 0 && conv_start == 1 && mux_sel == 4'b0111, "R7 collision restart", int'(mux_sel), 7);
      wait_idle();
      for (int k = 0; k < 4; k++)
         chk(slot(k)[9:6] == 4'b0111, "R1 after collision", int'(slot(k)[9:6]), 7);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule